// File: doc/BRIEF.md
# Sector Read/Write Sequencer

This block runs the data phase of an access to a 496-byte array. The array is split into 62 sectors of 8 bytes. Upstream logic checks the credentials and decodes the bus. It then pulses a grant together with a sector number and a direction. From that point the sequencer moves bytes between the byte strobes of the bus side and the array port. Every access starts at byte 0 of the named sector, and no other start point is possible.

A write gathers incoming bytes in an 8-entry staging buffer. Only a stop that closes a run of exactly 8 bytes copies the buffer into the sector. The copy takes one byte per cycle, in ascending address order. A busy interval follows, and the block turns away all new work until it ends. A run that is short, long or cut off by a start leaves the array as it was. A read presents the byte at the current address and steps one address on each strobe. It crosses sector boundaries freely and wraps from the last byte of the array back to byte 0. A start or a stop ends the read.

States: `ST_IDLE`, `ST_WR_COLLECT`, `ST_RD_STREAM`, `ST_COMMIT`, `ST_BUSY`.

Transitions:
- IDLE to WR_COLLECT or RD_STREAM: a grant arrives with a legal sector, and the direction picks which.
- WR_COLLECT to IDLE: a start arrives, or a stop arrives with the wrong byte count.
- WR_COLLECT to COMMIT: a stop arrives with a count of exactly 8.
- RD_STREAM to IDLE: a start or a stop arrives.
- COMMIT to BUSY: the 8th array write has been issued.
- BUSY to IDLE: the busy count has run out.

Top module: `sector_seq`

## Requirements
- R1: After reset, `mem_we_o`, `busy_o` and `rd_byte_o` are 0.
- R2: A read grant for sector s makes `rd_byte_o` show array byte s*8 in the cycle after the grant.
- R3: Each read strobe moves the read address up by one, and the address runs on into the next sector without a break.
- R4: After array byte 495, the next read strobe returns byte 0. `mem_addr_o` never exceeds 495.
- R5: A write of exactly 8 bytes followed by a stop writes the bytes to s*8 .. s*8+7, in the order they were received. The writes go out one per cycle, starting the cycle after the stop.
- R6: A stop after fewer than 8 write bytes causes no array write.
- R7: A stop after more than 8 write bytes causes no array write.
- R8: A start during write collection abandons the write with no array write. A later stop or byte strobe has no effect.
- R9: `busy_o` is 1 for exactly SECTOR_BYTES+BUSY_CYCLES cycles, starting the cycle after a committing stop (8+20 = 28 with the defaults). A grant during that time is ignored and `rd_byte_o` stays 0.
- R10: A byte strobe in the same cycle as a stop is counted before the stop is judged. Seven earlier bytes plus that byte commit. Eight earlier bytes plus that byte do not.
- R11: A grant with a sector number of 62 or more is ignored.
- R12: A start or a stop during a read returns `rd_byte_o` to 0 from the next cycle, with no array write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| grant_i | input | 1 | One-cycle pulse: access granted |
| sector_i | input | 6 | Sector number, sampled with the grant |
| dir_rd_i | input | 1 | Direction, sampled with the grant: 1 = read, 0 = write |
| byte_valid_i | input | 1 | Byte strobe: a write byte has arrived, or the current read byte has been taken |
| wr_byte_i | input | 8 | Write data byte, valid with the strobe |
| start_i | input | 1 | Start event seen on the bus |
| stop_i | input | 1 | Stop event seen on the bus |
| mem_rdata_i | input | 8 | Array read data for `mem_addr_o`, combinational |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | 9 | Array byte address |
| mem_wdata_o | output | 8 | Array write data |
| rd_byte_o | output | 8 | Current read byte; 0 when no read is active |
| busy_o | output | 1 | Commit or write cycle in progress |

## Verification
A byte strobe and a stop can arrive in the same cycle during write collection. The outcome then depends on the strobe being counted before the stop is judged. The bench drives both inputs at the same falling edge, after either seven or eight earlier bytes. It then judges the result from the array port: eight ordered writes in the first case, and no write at all in the second. A grant that lands inside the busy interval is the other collision. Its effect is judged from `rd_byte_o`, which must stay 0 both during the interval and after it ends.

// File: rtl/sseq_pkg.sv
package sseq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_COLLECT,
        ST_RD_STREAM,
        ST_COMMIT,
        ST_BUSY
    } sseq_state_e;
endpackage

// File: rtl/sseq_wbuf.sv
module sseq_wbuf #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] slot_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (wr_en) begin
            slot_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/sseq_rdptr.sv
module sseq_rdptr #(
    parameter int TOTAL  = 496,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(TOTAL - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ptr <= '0;
        else if (load)    ptr <= base;
        else if (step)    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
endmodule

// File: rtl/sseq_timer.sv
module sseq_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] last,
    output logic [W-1:0] cnt,
    output logic         done
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

    assign done = (cnt == last);
endmodule

// File: rtl/sector_seq.sv
module sector_seq
    import sseq_pkg::*;
#(
    parameter int NUM_SECTORS  = 62,
    parameter int SECTOR_BYTES = 8,
    parameter int DATA_W       = 8,
    parameter int BUSY_CYCLES  = 20,
    localparam int TOTAL  = NUM_SECTORS * SECTOR_BYTES,
    localparam int ADDR_W = $clog2(TOTAL),
    localparam int SEC_W  = $clog2(NUM_SECTORS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant_i,
    input  logic [SEC_W-1:0]  sector_i,
    input  logic              dir_rd_i,
    input  logic              byte_valid_i,
    input  logic [DATA_W-1:0] wr_byte_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [DATA_W-1:0] rd_byte_o,
    output logic              busy_o
);
    localparam int OFF_W   = $clog2(SECTOR_BYTES);
    localparam int CNT_W   = OFF_W + 1;
    localparam int TMR_MAX = (BUSY_CYCLES > SECTOR_BYTES) ? BUSY_CYCLES : SECTOR_BYTES;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(SECTOR_BYTES);

    sseq_state_e state_q, state_d;
    logic [SEC_W-1:0]  sector_q;
    logic [CNT_W-1:0]  wr_cnt_q;
    logic              ovf_q;
    logic [TMR_W-1:0]  tmr_cnt, tmr_last;
    logic              tmr_done;
    logic [ADDR_W-1:0] rptr, rbase, wbase;
    logic [DATA_W-1:0] buf_rd;
    logic              grant_ok, commit_ok, buf_we, rd_step;

    assign grant_ok  = grant_i && (32'(sector_i) < NUM_SECTORS);
    assign commit_ok = !ovf_q && (byte_valid_i ? (wr_cnt_q == FULL - 1'b1)
                                               : (wr_cnt_q == FULL));
    assign buf_we    = (state_q == ST_WR_COLLECT) && byte_valid_i && (wr_cnt_q != FULL);
    assign rd_step   = (state_q == ST_RD_STREAM) && byte_valid_i && !start_i && !stop_i;
    assign rbase     = ADDR_W'(sector_i) * ADDR_W'(SECTOR_BYTES);
    assign wbase     = ADDR_W'(sector_q) * ADDR_W'(SECTOR_BYTES);
    assign tmr_last  = (state_q == ST_COMMIT) ? TMR_W'(SECTOR_BYTES - 1)
                                              : TMR_W'(BUSY_CYCLES - 1);

    sseq_wbuf #(.DEPTH(SECTOR_BYTES), .DATA_W(DATA_W)) u_wbuf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(buf_we), .wr_idx(wr_cnt_q[OFF_W-1:0]), .wr_data(wr_byte_i),
        .rd_idx(tmr_cnt[OFF_W-1:0]), .rd_data(buf_rd)
    );

    sseq_rdptr #(.TOTAL(TOTAL), .ADDR_W(ADDR_W)) u_rdptr (
        .clk(clk), .rst_n(rst_n),
        .load((state_q == ST_IDLE) && grant_ok && dir_rd_i),
        .base(rbase), .step(rd_step), .ptr(rptr)
    );

    sseq_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .clear(state_d != state_q), .last(tmr_last),
        .cnt(tmr_cnt), .done(tmr_done)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (grant_ok) state_d = dir_rd_i ? ST_RD_STREAM : ST_WR_COLLECT;
            ST_WR_COLLECT: if (start_i) state_d = ST_IDLE;
                           else if (stop_i) state_d = commit_ok ? ST_COMMIT : ST_IDLE;
            ST_RD_STREAM:  if (start_i || stop_i) state_d = ST_IDLE;
            ST_COMMIT:     if (tmr_done) state_d = ST_BUSY;
            ST_BUSY:       if (tmr_done) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // state register and write-run bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            sector_q <= '0;
            wr_cnt_q <= '0;
            ovf_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && grant_ok) begin
                sector_q <= sector_i;
                wr_cnt_q <= '0;
                ovf_q    <= 1'b0;
            end else if (state_q == ST_WR_COLLECT && byte_valid_i) begin
                if (wr_cnt_q == FULL) ovf_q <= 1'b1;
                else                  wr_cnt_q <= wr_cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        rd_byte_o   = '0;
        busy_o      = 1'b0;
        unique case (state_q)
            ST_RD_STREAM: begin
                mem_addr_o = rptr;
                rd_byte_o  = mem_rdata_i;
            end
            ST_COMMIT: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = wbase + ADDR_W'(tmr_cnt[OFF_W-1:0]);
                mem_wdata_o = buf_rd;
                busy_o      = 1'b1;
            end
            ST_BUSY:  busy_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sseq_chk.sv
module sseq_chk #(
    parameter int TOTAL_BYTES  = 496,
    parameter int SECTOR_BYTES = 8,
    parameter int ADDR_W       = 9,
    parameter int DATA_W       = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_i,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] rd_byte_o,
    input logic              busy_o
);
    AST_WE_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o); // R9

    AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_o) |-> $past(stop_i)); // R5

    AST_COMMIT_AT_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_o) |-> (32'(mem_addr_o) % SECTOR_BYTES) == 0); // R5

    AST_COMMIT_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |-> mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)); // R5

    AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> rd_byte_o == '0); // R9

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(mem_addr_o) < TOTAL_BYTES); // R4
endmodule

bind sector_seq sseq_chk #(
    .TOTAL_BYTES(NUM_SECTORS * SECTOR_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES),
    .ADDR_W($clog2(NUM_SECTORS * SECTOR_BYTES)),
    .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .rd_byte_o(rd_byte_o), .busy_o(busy_o)
);

// File: tb/sector_seq_test.sv
`timescale 1ns/1ps
module sector_seq_test;
    localparam int TOTAL = 496;
    localparam int BUSY_TOTAL = 8 + 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       grant_i = 1'b0, dir_rd_i = 1'b0, byte_valid_i = 1'b0;
    logic       start_i = 1'b0, stop_i = 1'b0;
    logic [5:0] sector_i = '0;
    logic [7:0] wr_byte_i = '0;
    logic [7:0] mem_rdata_i, mem_wdata_o, rd_byte_o;
    logic [8:0] mem_addr_o;
    logic       mem_we_o, busy_o;

    logic [7:0] mem [TOTAL];
    logic [7:0] expm [TOTAL];
    int checks = 0, errors = 0, we_count = 0;

    always #5 clk = ~clk;

    sector_seq uut (
        .clk(clk), .rst_n(rst_n), .grant_i(grant_i), .sector_i(sector_i),
        .dir_rd_i(dir_rd_i), .byte_valid_i(byte_valid_i), .wr_byte_i(wr_byte_i),
        .start_i(start_i), .stop_i(stop_i), .mem_rdata_i(mem_rdata_i),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .rd_byte_o(rd_byte_o), .busy_o(busy_o)
    );

    assign mem_rdata_i = (32'(mem_addr_o) < TOTAL) ? mem[mem_addr_o] : 8'h00;

    always @(posedge clk) begin
        if (mem_we_o) begin
            mem[mem_addr_o] <= mem_wdata_o;
            we_count <= we_count + 1;
        end
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(); @(negedge clk); endtask

    task automatic grant(int sec, bit rd);
        @(negedge clk); grant_i = 1'b1; sector_i = 6'(sec); dir_rd_i = rd;
        @(negedge clk); grant_i = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] b);
        @(negedge clk); byte_valid_i = 1'b1; wr_byte_i = b;
        @(negedge clk); byte_valid_i = 1'b0;
    endtask

    task automatic advance();
        @(negedge clk); byte_valid_i = 1'b1;
        @(negedge clk); byte_valid_i = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    function automatic logic [7:0] pat(int sec, int i);
        return 8'((sec * 16 + i * 3) % 255 + 1);
    endfunction

    task automatic wait_idle(output int n);
        n = 0;
        while (busy_o && n < 1000) begin n++; cyc(); end
    endtask

    task automatic check_sector(string req, int sec);
        for (int i = 0; i < 8; i++) check(req, mem[sec*8+i], expm[sec*8+i]);
    endtask

    task automatic t_reset();
        check("R1 we", mem_we_o, 0);
        check("R1 busy", busy_o, 0);
        check("R1 rd_byte", rd_byte_o, 0);
    endtask

    task automatic t_read_start();
        grant(9, 1'b1);
        check("R2 first byte", rd_byte_o, mem[72]);
        pulse_stop();
    endtask

    task automatic t_read_cross();
        grant(5, 1'b1);
        for (int i = 1; i <= 10; i++) begin
            advance();
            check("R3 stream", rd_byte_o, mem[40+i]);
        end
        pulse_stop();
    endtask

    task automatic t_read_wrap();
        grant(61, 1'b1);
        for (int i = 0; i < 7; i++) advance();
        check("R4 last byte", rd_byte_o, mem[495]);
        advance();
        check("R4 wrap", rd_byte_o, mem[0]);
        advance();
        check("R4 after wrap", rd_byte_o, mem[1]);
        pulse_stop();
    endtask

    task automatic t_write_ok();
        int n, w0;
        w0 = we_count;
        grant(12, 1'b0);
        for (int i = 0; i < 8; i++) send_byte(pat(12, i));
        pulse_stop();
        for (int i = 0; i < 8; i++) expm[96+i] = pat(12, i);
        check("R9 busy after stop", busy_o, 1);
        wait_idle(n);
        check("R9 busy length", n, BUSY_TOTAL);
        check("R5 write count", we_count - w0, 8);
        check_sector("R5 sector data", 12);
        check_sector("R5 neighbour", 13);
    endtask

    task automatic t_write_short();
        int w0 = we_count;
        grant(20, 1'b0);
        for (int i = 0; i < 5; i++) send_byte(8'hEE);
        pulse_stop();
        repeat (12) cyc();
        check("R6 no write", we_count - w0, 0);
        check_sector("R6 unchanged", 20);
    endtask

    task automatic t_write_long();
        int w0 = we_count;
        grant(21, 1'b0);
        for (int i = 0; i < 9; i++) send_byte(8'hDD);
        pulse_stop();
        repeat (12) cyc();
        check("R7 no write", we_count - w0, 0);
        check_sector("R7 unchanged", 21);
    endtask

    task automatic t_write_abort();
        int w0 = we_count;
        grant(22, 1'b0);
        for (int i = 0; i < 8; i++) send_byte(8'hCC);
        pulse_start();
        send_byte(8'hCB);
        pulse_stop();
        repeat (12) cyc();
        check("R8 no write", we_count - w0, 0);
        check("R8 not busy", busy_o, 0);
        check_sector("R8 unchanged", 22);
    endtask

    task automatic t_same_cycle();
        int n, w0;
        w0 = we_count;
        grant(30, 1'b0);
        for (int i = 0; i < 7; i++) send_byte(pat(30, i));
        @(negedge clk); byte_valid_i = 1'b1; wr_byte_i = pat(30, 7); stop_i = 1'b1;
        @(negedge clk); byte_valid_i = 1'b0; stop_i = 1'b0;
        for (int i = 0; i < 8; i++) expm[240+i] = pat(30, i);
        wait_idle(n);
        check("R10 7+1 commits", we_count - w0, 8);
        check_sector("R10 7+1 data", 30);
        w0 = we_count;
        grant(31, 1'b0);
        for (int i = 0; i < 8; i++) send_byte(8'hAB);
        @(negedge clk); byte_valid_i = 1'b1; wr_byte_i = 8'hAC; stop_i = 1'b1;
        @(negedge clk); byte_valid_i = 1'b0; stop_i = 1'b0;
        repeat (12) cyc();
        check("R10 8+1 no write", we_count - w0, 0);
        check_sector("R10 8+1 unchanged", 31);
    endtask

    task automatic t_bad_sector();
        int w0 = we_count;
        grant(62, 1'b1);
        check("R11 read ignored", rd_byte_o, 0);
        advance();
        check("R11 read still ignored", rd_byte_o, 0);
        grant(63, 1'b0);
        for (int i = 0; i < 8; i++) send_byte(8'h77);
        pulse_stop();
        repeat (4) cyc();
        check("R11 write ignored", we_count - w0, 0);
        check("R11 not busy", busy_o, 0);
    endtask

    task automatic t_read_end();
        int w0 = we_count;
        grant(2, 1'b1);
        check("R12 read live", rd_byte_o, mem[16]);
        pulse_stop();
        check("R12 stop ends read", rd_byte_o, 0);
        grant(3, 1'b1);
        advance();
        check("R12 read live 2", rd_byte_o, mem[25]);
        pulse_start();
        check("R12 start ends read", rd_byte_o, 0);
        advance();
        check("R12 strobe after end", rd_byte_o, 0);
        check("R12 no write", we_count - w0, 0);
    endtask

    task automatic t_grant_busy();
        int n;
        grant(40, 1'b0);
        for (int i = 0; i < 8; i++) send_byte(pat(40, i));
        pulse_stop();
        for (int i = 0; i < 8; i++) expm[320+i] = pat(40, i);
        repeat (10) cyc();
        grant(3, 1'b1);
        check("R9 grant in busy", rd_byte_o, 0);
        wait_idle(n);
        check("R9 busy length 2", n, BUSY_TOTAL - 12);
        cyc();
        check("R9 grant dropped", rd_byte_o, 0);
        check_sector("R5 second commit", 40);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < TOTAL; i++) begin
            mem[i]  = 8'((i * 5) % 255 + 1);
            expm[i] = 8'((i * 5) % 255 + 1);
        end
        repeat (3) cyc();
        t_reset();
        rst_n = 1'b1;
        repeat (2) cyc();
        t_reset();
        t_read_start();
        t_read_cross();
        t_read_wrap();
        t_write_ok();
        t_write_short();
        t_write_long();
        t_write_abort();
        t_same_cycle();
        t_bad_sector();
        t_read_end();
        t_grant_busy();
        repeat (2) cyc();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule